// File: doc/BRIEF.md
# Cascadable Up/Down Binary Counter

This block is a small binary counter that steps up or down by one on each rising clock edge, with the direction chosen by a single level input. Counting happens only while an active-low enable is asserted; with the enable released the value is held. An active-low parallel load sets the counter from a data input at once, without waiting for a clock edge. A synchronous active-high reset clears the count.

Two outputs support building wider counters from several copies of the block. The limit flag is a level. It is high while the count sits at the end of its range in the current direction: all ones when counting up, all zeros when counting down. The strobe is an active-low pulse that covers the low half of the clock period while the limit flag is high and counting is enabled. With a shared clock, the next stage is enabled from the limit flag and the enable of the stage before it, which gives look-ahead carry. The strobe can serve as the next stage's enable or its clock.

Top module: `updown_cascade_cnt`

## Requirements
- R1: With load_n high, rst low, cnt_en_n low and dir_down low, each rising clock edge adds one to q modulo 2^W, so all ones is followed by zero.
- R2: With load_n high, rst low, cnt_en_n low and dir_down high, each rising clock edge subtracts one from q modulo 2^W, so zero is followed by all ones.
- R3: With load_n high, rst low and cnt_en_n high, q does not change on a rising clock edge.
- R4: While load_n is low, q equals din without any clock edge, and clock edges do not move it. The first enabled edge after load_n rises counts from the loaded value.
- R5: limit_hit is high exactly when q is all ones with dir_down low, or q is zero with dir_down high. It does not depend on cnt_en_n.
- R6: strobe_n is low exactly when limit_hit is high, cnt_en_n is low and clk is low. In every other case it is high.
- R7: With load_n high, a rising clock edge with rst high sets q to zero, whatever cnt_en_n is.
- R8: Three instances sharing clk, where stage k+1 is enabled when stage k is at its limit and enabled, count together as one 3W-bit up/down counter with carry and borrow across the stages.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock; the count changes on the rising edge |
| rst | input | 1 | Synchronous active-high clear |
| load_n | input | 1 | Active-low asynchronous parallel load |
| cnt_en_n | input | 1 | Active-low count enable |
| dir_down | input | 1 | 0 counts up, 1 counts down |
| din | input | W | Value to load |
| q | output | W | Current count |
| limit_hit | output | 1 | High at the end of the range for the current direction |
| strobe_n | output | 1 | Active-low cascade strobe during the low half of the clock |

## Verification
The in-design assertions check on every clock cycle that an enabled edge steps the count by one in the chosen direction, that a disabled edge holds it, that a reset edge clears it, and that the step from the limit wraps to the opposite end. They also check that the strobe stays high whenever the clock is high. The bench scenarios cover the rest. They show that the load appears at the output with no clock edge and survives edges while held, that carry and borrow ripple correctly through a three-stage chain over full sweeps in both directions, and that the limit flag and strobe of each stage match the value expected at every low clock phase.

// File: rtl/cnt_pkg.sv
package cnt_pkg;

    localparam int CNT_W_DEF = 4;

    typedef enum logic {
        DIR_UP   = 1'b0,
        DIR_DOWN = 1'b1
    } dir_e;

    typedef enum logic [1:0] {
        OP_HOLD  = 2'd0,
        OP_COUNT = 2'd1,
        OP_CLEAR = 2'd2
    } op_e;

    typedef struct packed {
        dir_e dir;
        op_e  op;
    } ctrl_t;

    function automatic op_e pick_op(input logic rst, input logic en_n);
        if (rst)
            return OP_CLEAR;
        else if (!en_n)
            return OP_COUNT;
        else
            return OP_HOLD;
    endfunction

endpackage

// File: rtl/updown_step.sv
module updown_step
    import cnt_pkg::*;
#(
    parameter int W = CNT_W_DEF
) (
    input  logic [W-1:0] cur,
    input  dir_e         dir,
    output logic [W-1:0] nxt
);
    localparam logic [W-1:0] ONE = {{(W-1){1'b0}}, 1'b1};

    always_comb begin
        if (dir == DIR_DOWN)
            nxt = cur - ONE;
        else
            nxt = cur + ONE;
    end
endmodule

// File: rtl/updown_limit.sv
module updown_limit
    import cnt_pkg::*;
#(
    parameter int W = CNT_W_DEF
) (
    input  logic [W-1:0] val,
    input  dir_e         dir,
    output logic         hit
);
    localparam logic [W-1:0] TOP = {W{1'b1}};
    localparam logic [W-1:0] BOT = {W{1'b0}};

    logic at_top, at_bot;

    assign at_top = (val == TOP);
    assign at_bot = (val == BOT);
    assign hit    = (dir == DIR_DOWN) ? at_bot : at_top;
endmodule

// File: rtl/updown_strobe.sv
module updown_strobe (
    input  logic clk,
    input  logic rst,
    input  logic hit,
    input  logic en_n,
    output logic strobe_n
);
    assign strobe_n = ~(hit & ~en_n & ~clk);

    // R6: while the clock is high the strobe must be idle
    a_r6_strobe_idle_high: assert property (
        @(negedge clk) disable iff (rst) strobe_n
    );
endmodule

// File: rtl/updown_cascade_cnt.sv
module updown_cascade_cnt
    import cnt_pkg::*;
#(
    parameter int W = CNT_W_DEF
) (
    input  logic         clk,
    input  logic         rst,
    input  logic         load_n,
    input  logic         cnt_en_n,
    input  logic         dir_down,
    input  logic [W-1:0] din,
    output logic [W-1:0] q,
    output logic         limit_hit,
    output logic         strobe_n
);
    localparam logic [W-1:0] ONE = {{(W-1){1'b0}}, 1'b1};

    ctrl_t        ctrl;
    logic [W-1:0] state_q;
    logic [W-1:0] step_val;

    always_comb begin
        ctrl.dir = dir_down ? DIR_DOWN : DIR_UP;
        ctrl.op  = pick_op(rst, cnt_en_n);
    end

    updown_step #(.W(W)) u_step (
        .cur (state_q),
        .dir (ctrl.dir),
        .nxt (step_val)
    );

    always_ff @(posedge clk or negedge load_n) begin
        if (!load_n) begin
            state_q <= din;
        end else begin
            case (ctrl.op)
                OP_CLEAR: state_q <= '0;
                OP_COUNT: state_q <= step_val;
                default:  state_q <= state_q;
            endcase
        end
    end

    // the load path is transparent at the output while held
    assign q = load_n ? state_q : din;

    updown_limit #(.W(W)) u_limit (
        .val (q),
        .dir (ctrl.dir),
        .hit (limit_hit)
    );

    updown_strobe u_strobe (
        .clk      (clk),
        .rst      (rst),
        .hit      (limit_hit),
        .en_n     (cnt_en_n),
        .strobe_n (strobe_n)
    );

    // R1: enabled up edge adds one
    a_r1_up_step: assert property (
        @(posedge clk) disable iff (rst)
        (load_n && !cnt_en_n && !dir_down) |=> (!load_n || q == $past(q) + ONE)
    );

    // R2: enabled down edge subtracts one
    a_r2_down_step: assert property (
        @(posedge clk) disable iff (rst)
        (load_n && !cnt_en_n && dir_down) |=> (!load_n || q == $past(q) - ONE)
    );

    // R3: disabled edge holds
    a_r3_hold: assert property (
        @(posedge clk) disable iff (rst)
        (load_n && cnt_en_n) |=> (!load_n || $stable(q))
    );

    // R5: stepping from the limit wraps to the opposite end
    a_r5_limit_wrap: assert property (
        @(posedge clk) disable iff (rst)
        (load_n && !cnt_en_n && limit_hit) |=>
            (!load_n || q == ($past(dir_down) ? {W{1'b1}} : {W{1'b0}}))
    );

    // R7: reset edge clears
    a_r7_clear: assert property (
        @(posedge clk) (rst && load_n) |=> (!load_n || q == '0)
    );
endmodule

// File: tb/updown_cascade_cnt_bench.sv
module updown_cascade_cnt_bench;
    localparam int CLK_PERIOD = 10;
    localparam int W = 4;
    localparam int N = 3;
    localparam int TW = W * N;

    logic clk = 1'b0;
    logic rst = 1'b1;
    logic load_n = 1'b1;
    logic g_en_n = 1'b1;
    logic dir_down = 1'b0;
    logic [TW-1:0] din_all = '0;

    logic [W-1:0] q_s [N];
    logic [N-1:0] hit_s;
    logic [N-1:0] stb_s;
    logic [N-1:0] en_s;

    int n_cmp = 0;
    int n_bad = 0;
    logic [TW-1:0] exp_v = '0;

    always #(CLK_PERIOD/2) clk = ~clk;

    assign en_s[0] = g_en_n;
    for (genvar k = 1; k < N; k++) begin : g_chain
        assign en_s[k] = ~(hit_s[k-1] & ~en_s[k-1]);
    end

    updown_cascade_cnt #(.W(W)) u_updown_cascade_cnt (
        .clk (clk), .rst (rst), .load_n (load_n), .cnt_en_n (en_s[0]),
        .dir_down (dir_down), .din (din_all[W-1:0]),
        .q (q_s[0]), .limit_hit (hit_s[0]), .strobe_n (stb_s[0])
    );
    for (genvar k = 1; k < N; k++) begin : g_stage
        updown_cascade_cnt #(.W(W)) u_stage (
            .clk (clk), .rst (rst), .load_n (load_n), .cnt_en_n (en_s[k]),
            .dir_down (dir_down), .din (din_all[k*W +: W]),
            .q (q_s[k]), .limit_hit (hit_s[k]), .strobe_n (stb_s[k])
        );
    end

    function automatic logic [TW-1:0] joined();
        return {q_s[2], q_s[1], q_s[0]};
    endfunction

    task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
        n_cmp++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s actual=%0h expected=%0h at %0t", tag, act, exp, $time);
        end
    endtask

    // expected limit flags and strobes, from exp_v and the inputs
    task automatic chk_flags(input string tag);
        logic act_en;
        logic lim;
        act_en = !g_en_n;
        for (int k = 0; k < N; k++) begin
            lim = dir_down ? (exp_v[k*W +: W] == '0) : (exp_v[k*W +: W] == {W{1'b1}});
            chk({tag, " R5 limit"}, {31'd0, hit_s[k]}, {31'd0, lim});
            chk({tag, " R6 strobe"}, {31'd0, stb_s[k]}, {31'd0, !(lim && act_en)});
            act_en = act_en && lim;
        end
    endtask

    task automatic tick(input string tag, input bit flags);
        @(posedge clk);
        if (rst && load_n) exp_v = '0;
        else if (load_n && !g_en_n) exp_v = dir_down ? exp_v - 1'b1 : exp_v + 1'b1;
        #1;
        if (flags) chk({tag, " R6 strobe-high"}, {29'd0, stb_s}, {29'd0, 3'b111});
        @(negedge clk);
        #1;
        chk({tag, " R8 value"}, {20'd0, joined()}, {20'd0, exp_v});
        if (flags) chk_flags(tag);
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        n_bad++;
        $display("FAIL watchdog expired");
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
        $finish;
    end

    initial begin
        tick("reset", 1'b0);
        tick("reset", 1'b0);
        chk("R7 reset state", {20'd0, joined()}, 32'd0);
        rst = 1'b0;

        // R1 up sweep through full wrap
        g_en_n = 1'b0; dir_down = 1'b0;
        for (int i = 0; i < (1 << TW) + 20; i++) tick("R1 up", 1'b1);

        // R3 hold
        g_en_n = 1'b1;
        for (int i = 0; i < 10; i++) tick("R3 hold", 1'b1);

        // R4 asynchronous load, seen before any edge
        din_all = 12'h5A3;
        load_n = 1'b0;
        #1;
        chk("R4 load immediate", {20'd0, joined()}, 32'h5A3);
        exp_v = 12'h5A3;
        g_en_n = 1'b0;
        for (int i = 0; i < 3; i++) begin
            @(posedge clk); #1;
            chk("R4 load held over edge", {20'd0, joined()}, 32'h5A3);
        end
        @(negedge clk); #1;
        load_n = 1'b1;
        for (int i = 0; i < 5; i++) tick("R4 after load", 1'b1);

        // R2 down sweep through full wrap
        dir_down = 1'b1;
        for (int i = 0; i < (1 << TW) + 20; i++) tick("R2 down", 1'b1);

        // R5 borrow across the boundary at zero
        din_all = 12'h002; load_n = 1'b0; #1; exp_v = 12'h002;
        @(negedge clk); #1; load_n = 1'b1;
        for (int i = 0; i < 6; i++) tick("R5 borrow", 1'b1);

        // R7 reset while counting
        rst = 1'b1;
        tick("R7 clear", 1'b0);
        chk("R7 cleared", {20'd0, joined()}, 32'd0);
        rst = 1'b0;
        dir_down = 1'b0;
        for (int i = 0; i < 4; i++) tick("R1 restart", 1'b1);

        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
        $finish;
    end
endmodule